// File: doc/BRIEF.md
# Cache-Block Zeroing Engine

This engine carries out a cache-block zero command. Each request brings a byte address, the result of the store-permission check from the translation stage, and a flag that marks whether the requester runs virtualized. The engine rounds the address down to the start of its block. It then writes zeros over the whole block as a burst of full-width beats on a simple memory write port. When the last beat is taken, it pulses a completion strobe.

If the permission check failed, the engine writes nothing. It pulses a fault strobe instead, with a one-bit fault class. The class is a store page fault for a requester that is not virtualized, and a guest-level store fault for one that is. Block size and port width are parameters. The block size must be a power of two and defaults to 64 bytes.

Top module: `blkzero_engine`

## Requirements
- R1: The first write beat carries the request address with its low log2(BLK_BYTES) bits forced to zero, so any byte inside a block selects that whole block.
- R2: A permitted request issues exactly BLK_BYTES/(DATA_W/8) beats. Their addresses start at the aligned base and rise by DATA_W/8 from one beat to the next.
- R3: Every beat carries all-zero data, with every byte-enable bit set to one.
- R4: A beat completes only on a cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, `wr_valid` stays high and `wr_addr` does not change.
- R5: `done` is high for exactly one cycle: the cycle after the final beat's handshake. `busy` is low in the cycle after `done`.
- R6: A request with `req_perm_ok` low issues no beat. `fault` is high for exactly one cycle, the cycle after acceptance. During that cycle `fault_kind` is 0 (store page fault) when `req_virt` was 0, and 1 (guest store fault) when `req_virt` was 1.
- R7: A request is accepted only when `busy` is low. A `req_valid` seen while `busy` is high, including in the `done` cycle, has no effect.
- R8: While reset is asserted, `busy`, `wr_valid`, `done`, `fault` and `fault_kind` are all 0. Reset abandons any burst in progress.
- R9: `busy` rises in the cycle after acceptance. It stays high through the `done` or `fault` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Zeroing request present |
| req_addr | input | ADDR_W | Any byte address inside the target block |
| req_perm_ok | input | 1 | Store-permission check passed |
| req_virt | input | 1 | Requester is virtualized |
| busy | output | 1 | Engine is handling a request |
| wr_valid | output | 1 | Write beat present |
| wr_addr | output | ADDR_W | Byte address of the write beat |
| wr_data | output | DATA_W | Write data, always zero |
| wr_be | output | DATA_W/8 | Byte enables, always all ones |
| wr_ready | input | 1 | Memory takes the beat this cycle |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| fault_kind | output | 1 | 0 = store page fault, 1 = guest store fault |

## Verification
The closest collision is between completing an operation and taking a new one. In the cycle where `done` pulses, the engine is still busy, so a request presented in that same cycle must be dropped.

The bench provokes this case twice. First it raises `req_valid` exactly in the `done` cycle, with a failing permission and the virtualized flag set, and removes it before the engine returns to idle. The check is that no `fault` and no beat follow. Second it presents a competing request in the middle of a stalled burst, and the check is that the burst's addresses and its count are unchanged.

// File: rtl/blkzero_pkg.sv
package blkzero_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_DONE  = 2'd2,
      ST_FAULT = 2'd3
   } zst_t;

   typedef enum logic {
      FK_STORE_PF    = 1'b0,
      FK_GUEST_STORE = 1'b1
   } fkind_t;
endpackage

// File: rtl/blkzero_align.sv
module blkzero_align #(
   parameter int ADDR_W    = 32,
   parameter int BLK_BYTES = 64
) (
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out
);
   localparam int OFF_LG = $clog2(BLK_BYTES);
   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << OFF_LG) - 64'd1);

   always_comb addr_out = addr_in & ~LOW_MASK;
endmodule

// File: rtl/blkzero_beat_ctr.sv
module blkzero_beat_ctr #(
   parameter int BEATS = 8,
   parameter int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [CNT_W-1:0] idx,
   output logic             last
);
   generate
      if (BEATS == 1) begin : g_single
         assign idx  = '0;
         assign last = 1'b1;
      end else begin : g_multi
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)   cnt_q <= '0;
            else if (clr) cnt_q <= '0;
            else if (adv) cnt_q <= cnt_q + 1'b1;
         end
         assign idx  = cnt_q;
         assign last = (cnt_q == CNT_W'(BEATS - 1));
      end
   endgenerate
endmodule

// File: rtl/blkzero_engine.sv
module blkzero_engine #(
   parameter int ADDR_W    = 32,
   parameter int BLK_BYTES = 64,
   parameter int DATA_W    = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic                  req_perm_ok,
   input  logic                  req_virt,
   output logic                  busy,
   output logic                  wr_valid,
   output logic [ADDR_W-1:0]     wr_addr,
   output logic [DATA_W-1:0]     wr_data,
   output logic [DATA_W/8-1:0]   wr_be,
   input  logic                  wr_ready,
   output logic                  done,
   output logic                  fault,
   output logic                  fault_kind
);
   import blkzero_pkg::*;

   localparam int STEP    = DATA_W / 8;
   localparam int STEP_LG = $clog2(STEP);
   localparam int BEATS   = BLK_BYTES / STEP;
   localparam int CNT_W   = (BEATS > 1) ? $clog2(BEATS) : 1;

   generate
      if ((BLK_BYTES <= 0) || ((BLK_BYTES & (BLK_BYTES - 1)) != 0)) begin : g_bad_blk
         $error("BLK_BYTES must be a power of two");
      end
      if ((DATA_W < 8) || ((STEP & (STEP - 1)) != 0) || ((DATA_W % 8) != 0)) begin : g_bad_dw
         $error("DATA_W must be 8 times a power of two");
      end
      if (STEP > BLK_BYTES) begin : g_bad_ratio
         $error("write port wider than one block");
      end
   endgenerate

   zst_t              state_q;
   fkind_t            kind_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] base_al;
   logic [CNT_W-1:0]  idx;
   logic              last;
   logic              accept;
   logic              beat_hs;

   assign accept  = req_valid && (state_q == ST_IDLE);
   assign beat_hs = (state_q == ST_WRITE) && wr_ready;

   blkzero_align #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) align_i (
      .addr_in  (req_addr),
      .addr_out (base_al)
   );

   blkzero_beat_ctr #(.BEATS(BEATS), .CNT_W(CNT_W)) ctr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .adv   (beat_hs),
      .idx   (idx),
      .last  (last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= FK_STORE_PF;
         base_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               base_q  <= base_al;
               kind_q  <= req_virt ? FK_GUEST_STORE : FK_STORE_PF;
               state_q <= req_perm_ok ? ST_WRITE : ST_FAULT;
            end
            ST_WRITE: if (beat_hs && last) state_q <= ST_DONE;
            ST_DONE:  state_q <= ST_IDLE;
            ST_FAULT: state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != ST_IDLE);
   assign wr_valid   = (state_q == ST_WRITE);
   assign wr_addr    = base_q | (ADDR_W'(idx) << STEP_LG);
   assign wr_data    = '0;
   assign wr_be      = '1;
   assign done       = (state_q == ST_DONE);
   assign fault      = (state_q == ST_FAULT);
   assign fault_kind = fault && (kind_q == FK_GUEST_STORE);
endmodule

// File: rtl/blkzero_engine_chk.sv
module blkzero_engine_chk #(
   parameter int ADDR_W    = 32,
   parameter int BLK_BYTES = 64,
   parameter int DATA_W    = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   req_addr,
   input logic                busy,
   input logic                wr_valid,
   input logic [ADDR_W-1:0]   wr_addr,
   input logic [DATA_W-1:0]   wr_data,
   input logic [DATA_W/8-1:0] wr_be,
   input logic                wr_ready,
   input logic                done,
   input logic                fault
);
   localparam int BEATS  = BLK_BYTES / (DATA_W / 8);
   localparam int HW     = $clog2(BEATS + 1) + 1;
   localparam int OFF_LG = $clog2(BLK_BYTES);
   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << OFF_LG) - 64'd1);

   logic [HW-1:0] hs_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)                    hs_cnt <= '0;
      else if (!busy)                hs_cnt <= '0;
      else if (wr_valid && wr_ready) hs_cnt <= hs_cnt + 1'b1;
   end

   // R1
   first_beat_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !$past(busy) |-> wr_addr == ($past(req_addr) & ~LOW_MASK));
   // R2
   beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> hs_cnt == HW'(BEATS));
   // R3
   zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_data == '0) && (&wr_be));
   // R4
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr));
   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);
   // R6
   fault_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !$past(busy) && !wr_valid && (hs_cnt == '0));
   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done && !fault |=> busy);
endmodule

bind blkzero_engine blkzero_engine_chk #(
   .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .DATA_W(DATA_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .busy(busy),
   .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
   .wr_ready(wr_ready), .done(done), .fault(fault)
);

// File: tb/blkzero_engine_tb_top.sv
`timescale 1ns/1ps
module blkzero_engine_tb_top;
   localparam int ADDR_W = 32;
   localparam int BLK    = 64;
   localparam int DW     = 64;
   localparam int STEP   = DW / 8;
   localparam int NBEAT  = BLK / STEP;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_perm_ok = 1'b0, req_virt = 1'b0, wr_ready = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic busy, wr_valid, done, fault, fault_kind;
   logic [ADDR_W-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic [DW/8-1:0] wr_be;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   blkzero_engine #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_perm_ok(req_perm_ok), .req_virt(req_virt), .busy(busy),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
      .wr_ready(wr_ready), .done(done), .fault(fault), .fault_kind(fault_kind)
   );

   // fields: addr[41:10] virt[9] perm_ok[8] ready pattern[7:0]
   localparam int NV = 6;
   localparam logic [41:0] VEC [NV] = '{
      {32'h0000_1000, 1'b0, 1'b1, 8'hFF},
      {32'h0000_207F, 1'b1, 1'b1, 8'hAA},
      {32'h1234_5679, 1'b0, 1'b1, 8'h0F},
      {32'hFFFF_FFC1, 1'b0, 1'b1, 8'h81},
      {32'h0000_3010, 1'b0, 1'b0, 8'hFF},
      {32'h0000_3010, 1'b1, 1'b0, 8'hFF}
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [31:0] addr, input bit virt, input bit ok,
                         input logic [7:0] pat, input bit inj_busy, input bit inj_done);
      logic [31:0] base = addr & ~32'(BLK - 1);
      int beats = 0, stalls = 0, cyc = 0;
      bit addr_ok = 1, data_ok = 1, saw_done = 0, saw_fault = 0, kind = 0;
      logic [31:0] bad_addr = '0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = addr; req_virt = virt; req_perm_ok = ok;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R9 busy after accept", busy, 1);
      for (int k = 0; k < 200; k++) begin
         cyc++;
         if (inj_busy && k == 2) begin
            req_valid = 1'b1; req_addr = 32'h0000_9000; req_perm_ok = 1'b0; req_virt = 1'b1;
         end else if (inj_busy && k == 3) begin
            req_valid = 1'b0;
         end
         if (wr_valid) begin
            wr_ready = pat[k % 8];
            if (wr_data != '0 || wr_be != '1) data_ok = 0;
            if (wr_addr != base + 32'(beats * STEP)) begin addr_ok = 0; bad_addr = wr_addr; end
            if (wr_ready) beats++; else stalls++;
         end else begin
            wr_ready = 1'b0;
         end
         if (done) begin
            saw_done = 1; kind = fault_kind;
            if (inj_done) begin req_valid = 1'b1; req_addr = 32'h0000_5000; req_perm_ok = 1'b0; req_virt = 1'b1; end
            break;
         end
         if (fault) begin saw_fault = 1; kind = fault_kind; break; end
         @(negedge clk);
      end
      if (ok) begin
         chk(addr_ok, "R1/R2 beat address", bad_addr, base);
         chk(data_ok, "R3 zero data full enables", data_ok, 1);
         chk(beats == NBEAT, "R2 beat count", beats, NBEAT);
         chk(cyc == NBEAT + stalls + 1, "R4 stall cycles", cyc, NBEAT + stalls + 1);
         chk(saw_done && !saw_fault, "R5 done seen", saw_done, 1);
         chk(kind == 0, "R6 fault_kind idle on success", kind, 0);
      end else begin
         chk(beats == 0, "R6 no beat on fault", beats, 0);
         chk(saw_fault && cyc == 1, "R6 fault after accept", cyc, 1);
         chk(kind == virt, "R6 fault class", kind, virt);
      end
      wr_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 0 && done == 0 && fault == 0, "R5 idle after pulse", {busy, done, fault}, 0);
      if (inj_done) begin
         @(negedge clk);
         chk(busy == 0 && fault == 0 && wr_valid == 0, "R7 request in done cycle dropped",
             {busy, fault, wr_valid}, 0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({busy, wr_valid, done, fault, fault_kind} == 0, "R8 reset outputs",
          {busy, wr_valid, done, fault, fault_kind}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0, "R8 idle after reset", busy, 0);

      for (int i = 0; i < NV; i++)
         run_op(VEC[i][41:10], VEC[i][9], VEC[i][8], VEC[i][7:0], 1'b0, 1'b0);

      // R7: competing failing request during a stalled burst
      run_op(32'h0000_4ABC, 1'b0, 1'b1, 8'h55, 1'b1, 1'b0);
      // R7: request in the done cycle
      run_op(32'h0000_6000, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b1);

      // R8: reset during a burst
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h0000_7008; req_perm_ok = 1'b1; req_virt = 1'b0;
      @(negedge clk);
      req_valid = 1'b0; wr_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk({busy, wr_valid, done, fault} == 0, "R8 reset aborts burst", {busy, wr_valid, done, fault}, 0);
      rst_n = 1'b1; wr_ready = 1'b0;
      @(negedge clk);
      chk(busy == 0 && wr_valid == 0, "R8 stays idle", {busy, wr_valid}, 0);

      // R6 after restart: non-virtualized fault class
      run_op(32'h0000_8001, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule